// File: doc/BRIEF.md
# Transmit Clock Source Selector

This block chooses which of three candidate clocks drives the transmit side of a T1/E1 framer: an externally supplied transmit clock, a clock recovered from the receive line, or a clock divided down from the master clock. A two-bit mode input makes the choice. In one mode the block also watches the external clock. If that clock goes quiet, the block moves to the recovered clock by itself and raises a flag.

Everything runs on a fast system clock. The three candidates are treated as data: each one is synchronised, and the selected one is re-registered onto the output. The external candidate also passes through an edge detector. A saturating counter measures how many system cycles have gone by since the last edge. The user sets the loss limit to the number of system cycles in one channel time, which is eight line-bit periods. The block returns to the external clock on the first new edge seen on it.

Top module: `txclk_source_sel`

## Requirements
- R1: During and after reset, until inputs propagate, `tx_clk_out` and `fallback_active` are 0, the loss counter is cleared and the registered mode is 2'b00.
- R2: With mode 2'b00, `tx_clk_out` follows the external clock and `fallback_active` stays 0, even when the external clock stops.
- R3: With mode 2'b01 and no loss declared, `tx_clk_out` follows the external clock.
- R4: With mode 2'b01, the counter increments on every system cycle without a synchronised external edge. A loss is declared once it equals `loss_limit`. From the next cycle, `fallback_active` is 1 and the output follows the recovered clock.
- R5: In fallback, the first synchronised edge of the external clock clears `fallback_active` and returns the output to the external clock. An edge in the same cycle as a loss declaration wins.
- R6: With mode 2'b10, `tx_clk_out` follows the scaled master clock. The external input has no effect, and `fallback_active` is 0.
- R7: With mode 2'b11, `tx_clk_out` follows the recovered clock. The external input has no effect, and `fallback_active` is 0.
- R8: Leaving mode 2'b01 clears `fallback_active` and the loss counter one cycle after the registered mode changes.
- R9: Each candidate passes through a two-stage synchroniser and one output register. A level change at an input reaches `tx_clk_out` on the third rising system-clock edge. A change of `mode_sel` is registered before use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 2 | Source mode: 00 external, 01 external with fallback, 10 scaled, 11 recovered |
| ext_clk_in | input | 1 | External transmit clock candidate |
| rec_clk_in | input | 1 | Recovered receive clock candidate |
| scaled_clk_in | input | 1 | Scaled master clock candidate |
| loss_limit | input | LIMIT_W | System cycles without an external edge that count as one channel time (at least 1) |
| tx_clk_out | output | 1 | Selected transmit clock, registered |
| fallback_active | output | 1 | High while mode 01 is running on the recovered clock |

## Verification
Two events can fall on the same cycle: the loss counter reaching its limit, and a fresh edge arriving on the external clock. When they coincide, the edge must win and no fallback may start. To provoke this, the bench halts the external clock for a sweep of gap lengths around the limit, so that one of those gaps lands the returning edge exactly on the limit cycle. The behavioural model decides each cycle whether fallback should be set, and the design's flag and output are compared against it. A second collision, a mode change while fallback is active, is provoked by changing modes during fallback and is judged the same way.

// File: rtl/txcs_pkg.sv
package txcs_pkg;
  typedef enum logic [1:0] {
    TXSRC_EXT    = 2'b00,
    TXSRC_AUTO   = 2'b01,
    TXSRC_SCALED = 2'b10,
    TXSRC_REC    = 2'b11
  } txsrc_mode_e;

  localparam int NUM_CAND   = 3;
  localparam int CAND_EXT   = 0;
  localparam int CAND_SCALE = 1;
  localparam int CAND_REC   = 2;
endpackage

// File: rtl/txcs_sync.sv
module txcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], raw_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/txcs_loss_det.sv
module txcs_loss_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         sig_i,
  input  logic [W-1:0] limit_i,
  output logic         edge_o,
  output logic         lost_o,
  output logic [W-1:0] cnt_o
);
  logic         prev_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign edge_o = sig_i ^ prev_q;

  // the counter only moves while armed and below the limit
  assign cnt_en = en_i && !edge_o && (cnt_q < limit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || edge_o) cnt_d = '0;
    else if (cnt_en)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sig_i;
      cnt_q  <= cnt_d;
    end
  end

  assign lost_o = en_i && (cnt_q == limit_i);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/txcs_src_mux.sv
module txcs_src_mux
  import txcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  txsrc_mode_e         mode_i,
  input  logic                fallback_i,
  input  logic [NUM_CAND-1:0] cand_i,
  output logic                clk_o
);
  logic sel_d;
  logic out_q;

  always_comb begin
    unique case (mode_i)
      TXSRC_EXT:    sel_d = cand_i[CAND_EXT];
      TXSRC_AUTO:   sel_d = fallback_i ? cand_i[CAND_REC] : cand_i[CAND_EXT];
      TXSRC_SCALED: sel_d = cand_i[CAND_SCALE];
      default:      sel_d = cand_i[CAND_REC];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= sel_d;
  end

  assign clk_o = out_q;
endmodule

// File: rtl/txclk_source_sel.sv
module txclk_source_sel
  import txcs_pkg::*;
#(
  parameter int LIMIT_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               ext_clk_in,
  input  logic               rec_clk_in,
  input  logic               scaled_clk_in,
  input  logic [LIMIT_W-1:0] loss_limit,
  output logic               tx_clk_out,
  output logic               fallback_active
);
  logic [NUM_CAND-1:0] cand_raw;
  logic [NUM_CAND-1:0] cand_sync;
  txsrc_mode_e         mode_q;
  logic                fb_q;
  logic                fb_d;
  logic                ext_edge;
  logic                ext_lost;
  logic [LIMIT_W-1:0]  loss_cnt;
  logic                auto_mode;

  assign cand_raw[CAND_EXT]   = ext_clk_in;
  assign cand_raw[CAND_SCALE] = scaled_clk_in;
  assign cand_raw[CAND_REC]   = rec_clk_in;

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
    txcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (cand_raw[g]),
      .sync_o (cand_sync[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= TXSRC_EXT;
    else        mode_q <= txsrc_mode_e'(mode_sel);
  end

  assign auto_mode = (mode_q == TXSRC_AUTO);

  txcs_loss_det #(.W(LIMIT_W)) u_loss (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (auto_mode),
    .sig_i   (cand_sync[CAND_EXT]),
    .limit_i (loss_limit),
    .edge_o  (ext_edge),
    .lost_o  (ext_lost),
    .cnt_o   (loss_cnt)
  );

  // a fresh edge outranks a loss declared in the same cycle
  always_comb begin
    fb_d = auto_mode && !ext_edge && (fb_q || ext_lost);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= fb_d;
  end

  txcs_src_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_q),
    .fallback_i (fb_q),
    .cand_i     (cand_sync),
    .clk_o      (tx_clk_out)
  );

  assign fallback_active = fb_q;
endmodule

// File: rtl/txcs_checker.sv
module txcs_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_q,
  input logic         ext_clk_in,
  input logic         rec_clk_in,
  input logic         scaled_clk_in,
  input logic [W-1:0] loss_limit,
  input logic [W-1:0] loss_cnt,
  input logic         ext_edge,
  input logic         tx_clk_out,
  input logic         fallback_active
);
  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd4)  age_q <= age_q + 3'd1;
  end

  // R2
  ext_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 && mode_q == 2'b00) |=>
      (tx_clk_out == $past(ext_clk_in, 3) && !fallback_active));

  // R3
  auto_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 && mode_q == 2'b01 && !fallback_active) |=>
      (tx_clk_out == $past(ext_clk_in, 3)));

  // R4
  loss_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fallback_active) |->
      ($past(loss_cnt) == $past(loss_limit) && $past(mode_q) == 2'b01));

  // R5
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && ext_edge) |=> !fallback_active);

  // R6
  scaled_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 && mode_q == 2'b10) |=>
      (tx_clk_out == $past(scaled_clk_in, 3) && !fallback_active));

  // R7
  rec_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 && mode_q == 2'b11) |=>
      (tx_clk_out == $past(rec_clk_in, 3) && !fallback_active));

  // R8
  exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b01) |=> (!fallback_active && loss_cnt == '0));
endmodule

bind txclk_source_sel txcs_checker #(.W(LIMIT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode_q          (mode_q),
  .ext_clk_in      (ext_clk_in),
  .rec_clk_in      (rec_clk_in),
  .scaled_clk_in   (scaled_clk_in),
  .loss_limit      (loss_limit),
  .loss_cnt        (loss_cnt),
  .ext_edge        (ext_edge),
  .tx_clk_out      (tx_clk_out),
  .fallback_active (fallback_active)
);

// File: tb/txclk_source_sel_test.sv
module txclk_source_sel_test;
  localparam int LW    = 8;
  localparam int LIMIT = 16;
  localparam int EXT_H = 3;
  localparam int SC_H  = 5;
  localparam int REC_H = 2;

  logic          clk;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          ext_in, rec_in, sc_in;
  logic [LW-1:0] loss_limit;
  logic          tx_clk_out, fallback_active;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 0;
  bit ext_run = 1, rec_run = 1, sc_run = 1;
  int ce = 0, cr = 0, cs = 0;

  // behavioural reference state
  logic [2:0] hist[$];
  int         m_cnt;
  logic       m_fb, m_out;
  logic [1:0] m_mode;

  txclk_source_sel #(.LIMIT_W(LW)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_sel        (mode_sel),
    .ext_clk_in      (ext_in),
    .rec_clk_in      (rec_in),
    .scaled_clk_in   (sc_in),
    .loss_limit      (loss_limit),
    .tx_clk_out      (tx_clk_out),
    .fallback_active (fallback_active)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // hist[0]: last sample, hist[1]: two samples ago, hist[2]: three ago
  always @(posedge clk or negedge rst_n) begin : model
    logic [2:0] s2;
    logic       edg, lost, nfb, nout;
    int         ncnt;
    if (!rst_n) begin
      hist   = '{3'b000, 3'b000, 3'b000};
      m_cnt  = 0;
      m_fb   = 1'b0;
      m_out  = 1'b0;
      m_mode = 2'b00;
    end else begin
      s2   = hist[1];
      edg  = hist[1][0] ^ hist[2][0];
      lost = (m_mode == 2'b01) && (m_cnt == int'(loss_limit));
      case (m_mode)
        2'b00:   nout = s2[0];
        2'b01:   nout = m_fb ? s2[2] : s2[0];
        2'b10:   nout = s2[1];
        default: nout = s2[2];
      endcase
      if (m_mode != 2'b01 || edg)     ncnt = 0;
      else if (m_cnt < int'(loss_limit)) ncnt = m_cnt + 1;
      else                            ncnt = m_cnt;
      nfb    = (m_mode == 2'b01) && !edg && (m_fb || lost);
      m_out  = nout;
      m_fb   = nfb;
      m_cnt  = ncnt;
      hist.push_front({rec_in, sc_in, ext_in});
      void'(hist.pop_back());
      m_mode = mode_sel;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string tag_now();
    case (m_mode)
      2'b00:   return "R2";
      2'b01:   return m_fb ? "R4" : "R3";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(tag_now(), "tx_clk_out", tx_clk_out, m_out);
      chk(tag_now(), "fallback_active", fallback_active, m_fb);
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ext_run) begin ce++; if (ce >= EXT_H) begin ce = 0; ext_in = ~ext_in; end end
      if (sc_run)  begin cs++; if (cs >= SC_H)  begin cs = 0; sc_in  = ~sc_in;  end end
      if (rec_run) begin cr++; if (cr >= REC_H) begin cr = 0; rec_in = ~rec_in; end end
    end
  endtask

  task automatic ext_restart();
    @(negedge clk);
    ext_in  = ~ext_in;
    ce      = 0;
    ext_run = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    rst_n      = 1'b0;
    mode_sel   = 2'b00;
    loss_limit = LW'(LIMIT);
    ext_in     = 1'b1;
    rec_in     = 1'b1;
    sc_in      = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state with all candidates high
    chk("R1", "tx_clk_out in reset", tx_clk_out, 1'b0);
    chk("R1", "fallback_active in reset", fallback_active, 1'b0);
    rst_n  = 1'b1;
    cmp_en = 1;
    @(negedge clk);
    chk("R1", "tx_clk_out after release", tx_clk_out, 1'b0);

    // R2: external source, then external stops
    run(40);
    ext_run = 0;
    run(60);
    chk("R2", "no fallback with stopped ext", fallback_active, 1'b0);

    // R9: input-to-output latency
    ext_in = 1'b0;
    run(8);
    @(negedge clk); ext_in = 1'b1;
    @(negedge clk); chk("R9", "out after 1 edge", tx_clk_out, 1'b0);
    @(negedge clk); chk("R9", "out after 2 edges", tx_clk_out, 1'b0);
    @(negedge clk); chk("R9", "out after 3 edges", tx_clk_out, 1'b1);

    // R3 / R4 / R5: automatic mode
    mode_sel = 2'b01;
    ext_run  = 1;
    run(40);
    chk("R3", "no fallback with active ext", fallback_active, 1'b0);
    ext_run = 0;
    run(40);
    chk("R4", "fallback after silence", fallback_active, 1'b1);
    ext_restart();
    run(4);
    chk("R5", "fallback cleared by edge", fallback_active, 1'b0);

    // R5 collision sweep: gap lengths around the limit
    for (int gap = LIMIT - 3; gap <= LIMIT + 3; gap++) begin
      run(10);
      ext_run = 0;
      ce      = 0;
      run(gap);
      ext_restart();
      run(12);
    end

    // R4 with a different limit
    loss_limit = LW'(5);
    run(10);
    ext_run = 0;
    run(20);
    chk("R4", "fallback with short limit", fallback_active, 1'b1);

    // R8: leave auto mode while in fallback
    mode_sel = 2'b10;
    run(3);
    chk("R8", "fallback cleared on mode exit", fallback_active, 1'b0);

    // R6: scaled source, external activity ignored
    ext_run = 1;
    run(30);
    sc_run = 0;
    run(30);
    chk("R6", "stopped scaled holds out", tx_clk_out, m_out);
    ext_run = 0;
    sc_run  = 1;
    run(20);

    // R8 again: fallback then switch to 00
    mode_sel = 2'b01;
    run(30);
    chk("R4", "fallback re-entered", fallback_active, 1'b1);
    mode_sel = 2'b00;
    run(3);
    chk("R8", "fallback cleared into mode 00", fallback_active, 1'b0);

    // R7: recovered source, external activity ignored
    mode_sel = 2'b11;
    ext_run  = 1;
    run(30);
    rec_run = 0;
    run(20);
    chk("R7", "fallback low in mode 11", fallback_active, 1'b0);
    rec_run = 1;
    run(20);

    cmp_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule